// File: doc/BRIEF.md
# Shared-Period Eight-Channel PWM Timer

This block produces eight edge-aligned pulse-width-modulated outputs from one common time base. A single up-counter, fed by one of three tick-enable sources through a power-of-two prescaler, runs from a programmable start value up to a programmable terminal value and then wraps. Every channel compares that shared count against its own threshold, so all channels share one period but each has its own duty. Each channel also has an inversion bit, a mask bit and an enable bit.

Configuration arrives over a single-cycle write port: address, data and a write strobe. A lock latch can freeze the whole configuration against stray writes until an explicit unlock. Period and threshold changes made while the counter runs are held in shadow registers and only applied at the wrap, so no truncated or stretched pulse ever appears on a pin. The outputs come out of reset masked and disabled.

Top module: `pwm_shared_timer`

## Requirements
- R1: After reset every output is low: all mask bits are 1, all inversion bits are 0, all enable bits are 0 and the counter is stopped.
- R2: For an enabled, unmasked, non-inverted channel the output is high while count < threshold and low otherwise, so a threshold of 0 gives 0% duty and a threshold above the terminal value gives 100%. With start value 0 the period is terminal value + 1 counter steps. Terminal value is written at address 1 (bits [15:0]); the threshold of channel n at address 8+n (bits [16:0]).
- R3: The control word at address 0 carries a prescale code p in bits [2:0]; the counter steps once every 2^p source ticks, for p from 0 to 7.
- R4: Control bits [4:3] pick the source: 0 stops the counter and holds it at the start value, 1 uses `tick_sys`, 2 `tick_fix`, 3 `tick_ext`.
- R5: The counter counts from the start value (address 2, bits [15:0]) up to the terminal value and then returns to the start value, giving terminal − start + 1 steps per period.
- R6: Mask bit n (address 3, bit n; reset value all ones) set to 1 forces channel n to its inactive level, which equals its inversion bit.
- R7: Inversion bit n (address 4, bit n) set to 1 inverts the unmasked waveform of channel n.
- R8: A write to address 5 with bit 0 set engages the lock; while locked, writes to addresses 0–4 and 8–15 have no effect. A write to address 6 with bit 0 set releases it. The lock is released after reset.
- R9: While the counter runs, new terminal and threshold values take effect only at the next wrap; while it is stopped they take effect at once.
- R10: Control bit 16+n enables channel n; a disabled channel drives low regardless of its mask and inversion bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_sys | input | 1 | Tick enable of source 1 |
| tick_fix | input | 1 | Tick enable of source 2 |
| tick_ext | input | 1 | Tick enable of source 3 |
| wr_en | input | 1 | Write strobe, one write per cycle |
| wr_addr | input | 4 | Register address |
| wr_data | input | 32 | Write data |
| pwm_out | output | 8 | PWM outputs, bit n is channel n |

## Verification
The hardest situation to reach is a threshold or terminal-value write that lands mid-period, because the outputs alone do not reveal the counter phase. The stimulus makes that phase known by stopping the counter, which parks it at the start value, and restarting it with a write; every later cycle then has a known count, so a threshold change can be placed at a chosen count and the pin checked both before and after the wrap. Duty checks elsewhere count high cycles over exactly one period, which is independent of phase.

// File: rtl/pwm_timer_pkg.sv
package pwm_timer_pkg;

  typedef enum logic [1:0] {
    SRC_OFF = 2'd0,
    SRC_SYS = 2'd1,
    SRC_FIX = 2'd2,
    SRC_EXT = 2'd3
  } src_sel_e;

  localparam int unsigned ADR_CTRL   = 0;
  localparam int unsigned ADR_PERIOD = 1;
  localparam int unsigned ADR_START  = 2;
  localparam int unsigned ADR_MASK   = 3;
  localparam int unsigned ADR_POL    = 4;
  localparam int unsigned ADR_LOCK   = 5;
  localparam int unsigned ADR_UNLOCK = 6;
  localparam int unsigned ADR_CMP0   = 8;

  localparam int unsigned CTRL_PS_LSB  = 0;
  localparam int unsigned CTRL_SRC_LSB = 3;
  localparam int unsigned CTRL_EN_LSB  = 16;

endpackage

// File: rtl/pwm_cfg_regs.sv
module pwm_cfg_regs
  import pwm_timer_pkg::*;
#(
  parameter int NCH       = 8,
  parameter int CNT_W     = 16,
  parameter int ADDR_W    = 4,
  parameter int DATA_W    = 32,
  parameter int PS_W      = 3,
  parameter bit HAS_CH_EN = 1'b1
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         wr_en,
  input  logic [ADDR_W-1:0]            wr_addr,
  input  logic [DATA_W-1:0]            wr_data,
  output logic [1:0]                   src_o,
  output logic [PS_W-1:0]              ps_o,
  output logic [CNT_W-1:0]             period_o,
  output logic [CNT_W-1:0]             start_o,
  output logic [NCH-1:0]               mask_o,
  output logic [NCH-1:0]               pol_o,
  output logic [NCH-1:0]               chen_o,
  output logic [NCH-1:0][CNT_W:0]      cmp_o
);

  localparam int CMP_W = CNT_W + 1;
  localparam logic [ADDR_W-1:0] A_CTRL   = ADDR_W'(ADR_CTRL);
  localparam logic [ADDR_W-1:0] A_PERIOD = ADDR_W'(ADR_PERIOD);
  localparam logic [ADDR_W-1:0] A_START  = ADDR_W'(ADR_START);
  localparam logic [ADDR_W-1:0] A_MASK   = ADDR_W'(ADR_MASK);
  localparam logic [ADDR_W-1:0] A_POL    = ADDR_W'(ADR_POL);
  localparam logic [ADDR_W-1:0] A_LOCK   = ADDR_W'(ADR_LOCK);
  localparam logic [ADDR_W-1:0] A_UNLOCK = ADDR_W'(ADR_UNLOCK);

  logic                lock_q;
  logic                cfg_we;
  logic [1:0]          src_q;
  logic [PS_W-1:0]     ps_q;
  logic [CNT_W-1:0]    period_q;
  logic [CNT_W-1:0]    start_q;
  logic [NCH-1:0]      mask_q;
  logic [NCH-1:0]      pol_q;
  logic                unused_wdata;

  assign unused_wdata = ^wr_data;

  // Configuration writes pass only while the lock latch is open.
  assign cfg_we = wr_en && !lock_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lock_q <= 1'b0;
    end else if (wr_en && wr_addr == A_LOCK && wr_data[0]) begin
      lock_q <= 1'b1;
    end else if (wr_en && wr_addr == A_UNLOCK && wr_data[0]) begin
      lock_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      src_q    <= 2'(SRC_OFF);
      ps_q     <= '0;
      period_q <= '0;
      start_q  <= '0;
      mask_q   <= '1;
      pol_q    <= '0;
    end else if (cfg_we) begin
      case (wr_addr)
        A_CTRL: begin
          ps_q  <= wr_data[CTRL_PS_LSB +: PS_W];
          src_q <= wr_data[CTRL_SRC_LSB +: 2];
        end
        A_PERIOD: period_q <= wr_data[CNT_W-1:0];
        A_START:  start_q  <= wr_data[CNT_W-1:0];
        A_MASK:   mask_q   <= wr_data[NCH-1:0];
        A_POL:    pol_q    <= wr_data[NCH-1:0];
        default: ;
      endcase
    end
  end

  generate
    if (HAS_CH_EN) begin : g_chen
      logic [NCH-1:0] chen_q;
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          chen_q <= '0;
        end else if (cfg_we && wr_addr == A_CTRL) begin
          chen_q <= wr_data[CTRL_EN_LSB +: NCH];
        end
      end
      assign chen_o = chen_q;
    end else begin : g_nochen
      assign chen_o = '1;
    end
  endgenerate

  generate
    for (genvar n = 0; n < NCH; n++) begin : g_cmp
      localparam logic [ADDR_W-1:0] A_CMP = ADDR_W'(ADR_CMP0 + n);
      logic [CMP_W-1:0] cmp_q;
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          cmp_q <= '0;
        end else if (cfg_we && wr_addr == A_CMP) begin
          cmp_q <= wr_data[CMP_W-1:0];
        end
      end
      assign cmp_o[n] = cmp_q;
    end
  endgenerate

  assign src_o    = src_q;
  assign ps_o     = ps_q;
  assign period_o = period_q;
  assign start_o  = start_q;
  assign mask_o   = mask_q;
  assign pol_o    = pol_q;

  AST_LOCK_FREEZES_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_q && wr_en && wr_addr == A_MASK) |=> $stable(mask_q)); // R8
  AST_LOCK_FREEZES_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_q && wr_en && wr_addr == A_PERIOD) |=> $stable(period_q)); // R8

endmodule

// File: rtl/pwm_tick_gen.sv
module pwm_tick_gen
  import pwm_timer_pkg::*;
#(
  parameter int PS_W = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [1:0]      src_i,
  input  logic [PS_W-1:0] ps_i,
  input  logic            tick_sys_i,
  input  logic            tick_fix_i,
  input  logic            tick_ext_i,
  output logic            running_o,
  output logic            step_o
);

  localparam int DIV_W = (1 << PS_W) - 1;

  // Low ps bits all ones: the divider has seen 2^ps ticks.
  function automatic logic [DIV_W-1:0] div_mask(input logic [PS_W-1:0] ps);
    logic [DIV_W:0] t;
    t = ({{DIV_W{1'b0}}, 1'b1} << ps) - 1'b1;
    return t[DIV_W-1:0];
  endfunction

  logic             tick_sel;
  logic [DIV_W-1:0] div_q;
  logic [DIV_W-1:0] m;

  always_comb begin
    case (src_sel_e'(src_i))
      SRC_SYS: tick_sel = tick_sys_i;
      SRC_FIX: tick_sel = tick_fix_i;
      SRC_EXT: tick_sel = tick_ext_i;
      default: tick_sel = 1'b0;
    endcase
  end

  assign running_o = (src_i != 2'(SRC_OFF));
  assign m         = div_mask(ps_i);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      div_q <= '0;
    end else if (!running_o) begin
      div_q <= '0;
    end else if (tick_sel) begin
      div_q <= div_q + 1'b1;
    end
  end

  assign step_o = running_o && tick_sel && ((div_q & m) == m);

  AST_PRESCALE_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    (step_o && ps_i != '0) |=> (!step_o || ps_i != $past(ps_i))); // R3

endmodule

// File: rtl/pwm_counter.sv
module pwm_counter #(
  parameter int NCH   = 8,
  parameter int CNT_W = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    running_i,
  input  logic                    step_i,
  input  logic [CNT_W-1:0]        period_i,
  input  logic [CNT_W-1:0]        start_i,
  input  logic [NCH-1:0][CNT_W:0] cmp_i,
  output logic [CNT_W-1:0]        cnt_o,
  output logic [CNT_W-1:0]        mod_o,
  output logic [NCH-1:0][CNT_W:0] cmp_act_o,
  output logic                    wrap_o
);

  logic [CNT_W-1:0]        cnt_q;
  logic [CNT_W-1:0]        mod_q;
  logic [NCH-1:0][CNT_W:0] cmp_q;
  logic                    load_shadow;

  assign wrap_o      = step_i && (cnt_q >= mod_q);
  assign load_shadow = !running_i || wrap_o;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (!running_i) begin
      cnt_q <= start_i;
    end else if (step_i) begin
      cnt_q <= wrap_o ? start_i : cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mod_q <= '0;
      cmp_q <= '0;
    end else if (load_shadow) begin
      mod_q <= period_i;
      cmp_q <= cmp_i;
    end
  end

  assign cnt_o     = cnt_q;
  assign mod_o     = mod_q;
  assign cmp_act_o = cmp_q;

  AST_WRAP_TO_START: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_o |=> (cnt_q == $past(start_i))); // R5
  AST_STOP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !running_i |=> (cnt_q == $past(start_i))); // R4
  AST_SHADOW_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (running_i && !wrap_o) |=> ($stable(mod_q) && $stable(cmp_q))); // R9

endmodule

// File: rtl/pwm_channel.sv
module pwm_channel #(
  parameter int CNT_W = 16
) (
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [CNT_W:0]   cmp_i,
  input  logic             mask_i,
  input  logic             pol_i,
  input  logic             en_i,
  output logic             pwm_o
);

  function automatic logic in_active_phase(input logic [CNT_W-1:0] c,
                                           input logic [CNT_W:0]   v);
    return {1'b0, c} < v;
  endfunction

  logic raw;

  assign raw   = in_active_phase(cnt_i, cmp_i);
  assign pwm_o = en_i & (mask_i ? pol_i : (raw ^ pol_i));

endmodule

// File: rtl/pwm_shared_timer.sv
module pwm_shared_timer
  import pwm_timer_pkg::*;
#(
  parameter int NCH       = 8,
  parameter int CNT_W     = 16,
  parameter int ADDR_W    = 4,
  parameter int DATA_W    = 32,
  parameter int PS_W      = 3,
  parameter bit HAS_CH_EN = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_sys,
  input  logic              tick_fix,
  input  logic              tick_ext,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [NCH-1:0]    pwm_out
);

  logic [1:0]              src;
  logic [PS_W-1:0]         ps;
  logic [CNT_W-1:0]        period_sh;
  logic [CNT_W-1:0]        start_val;
  logic [NCH-1:0]          mask;
  logic [NCH-1:0]          pol;
  logic [NCH-1:0]          chen;
  logic [NCH-1:0][CNT_W:0] cmp_sh;
  logic                    running;
  logic                    step;
  logic [CNT_W-1:0]        cnt;
  logic [CNT_W-1:0]        mod_act;
  logic [NCH-1:0][CNT_W:0] cmp_act;
  logic                    wrap_evt;

  pwm_cfg_regs #(
    .NCH(NCH), .CNT_W(CNT_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .PS_W(PS_W), .HAS_CH_EN(HAS_CH_EN)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .src_o(src), .ps_o(ps), .period_o(period_sh),
    .start_o(start_val), .mask_o(mask), .pol_o(pol), .chen_o(chen),
    .cmp_o(cmp_sh)
  );

  pwm_tick_gen #(.PS_W(PS_W)) u_tick (
    .clk(clk), .rst_n(rst_n), .src_i(src), .ps_i(ps),
    .tick_sys_i(tick_sys), .tick_fix_i(tick_fix), .tick_ext_i(tick_ext),
    .running_o(running), .step_o(step)
  );

  pwm_counter #(.NCH(NCH), .CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .running_i(running), .step_i(step),
    .period_i(period_sh), .start_i(start_val), .cmp_i(cmp_sh),
    .cnt_o(cnt), .mod_o(mod_act), .cmp_act_o(cmp_act), .wrap_o(wrap_evt)
  );

  generate
    for (genvar n = 0; n < NCH; n++) begin : g_ch
      pwm_channel #(.CNT_W(CNT_W)) u_ch (
        .cnt_i(cnt), .cmp_i(cmp_act[n]), .mask_i(mask[n]), .pol_i(pol[n]),
        .en_i(chen[n]), .pwm_o(pwm_out[n])
      );

      AST_FULL_DUTY: assert property (@(posedge clk) disable iff (!rst_n)
        (chen[n] && !mask[n] && !pol[n] && cmp_act[n] > {1'b0, mod_act}
         && cnt <= mod_act) |-> pwm_out[n]); // R2
      AST_ZERO_DUTY: assert property (@(posedge clk) disable iff (!rst_n)
        (chen[n] && !mask[n] && !pol[n] && cmp_act[n] == '0) |-> !pwm_out[n]); // R2
      AST_MASK_INACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (chen[n] && mask[n]) |-> (pwm_out[n] == pol[n])); // R6
      AST_DISABLED_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !chen[n] |-> !pwm_out[n]); // R10
    end
  endgenerate

endmodule

// File: tb/tb_pwm_shared_timer.sv
`timescale 1ns/1ps
module tb_pwm_shared_timer;
  localparam int NCH    = 8;
  localparam int ADDR_W = 4;
  localparam int DATA_W = 32;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              tick_sys = 1'b1;
  logic              tick_fix = 1'b0;
  logic              tick_ext = 1'b0;
  logic              wr_en = 1'b0;
  logic [ADDR_W-1:0] wr_addr = '0;
  logic [DATA_W-1:0] wr_data = '0;
  logic [NCH-1:0]    pwm_out;

  int n_chk  = 0;
  int n_fail = 0;
  int phase3 = 0;
  int hi_cnt [NCH];

  always #5 clk = ~clk;

  pwm_shared_timer dut (
    .clk(clk), .rst_n(rst_n), .tick_sys(tick_sys), .tick_fix(tick_fix),
    .tick_ext(tick_ext), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .pwm_out(pwm_out)
  );

  // One cycle: fix source ticks every 2nd cycle, ext every 3rd.
  task automatic cyc();
    @(negedge clk);
    tick_fix = ~tick_fix;
    phase3   = (phase3 + 1) % 3;
    tick_ext = (phase3 == 0);
  endtask

  task automatic wr(input int a, input int d);
    wr_en   = 1'b1;
    wr_addr = ADDR_W'(a);
    wr_data = DATA_W'(d);
    cyc();
    wr_en   = 1'b0;
  endtask

  task automatic chk(input string req, input int got, input int exp);
    n_chk++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s got=%0d exp=%0d", req, got, exp);
    end
  endtask

  task automatic measure(input int len);
    for (int n = 0; n < NCH; n++) hi_cnt[n] = 0;
    for (int i = 0; i < len; i++) begin
      cyc();
      for (int n = 0; n < NCH; n++) hi_cnt[n] += int'(pwm_out[n]);
    end
  endtask

  // High cycles expected over one full period.
  function automatic int exp_high(input int modv, input int startv,
                                  input int cmpv, input int psv, input int dv,
                                  input int polb, input int maskb, input int enb);
    int span, lo, total, hi;
    span  = modv - startv + 1;
    lo    = ((cmpv < modv + 1) ? cmpv : modv + 1) - startv;
    if (lo < 0) lo = 0;
    total = (span << psv) * dv;
    hi    = (lo << psv) * dv;
    if (enb == 0) return 0;
    if (maskb != 0) return (polb != 0) ? total : 0;
    return (polb != 0) ? total - hi : hi;
  endfunction

  task automatic run_cfg(input string tag, input int modv, input int psv,
                         input int srcv, input int startv, input int polv,
                         input int maskv, input int env, input int cofs);
    int dv;
    int len;
    wr(0, 0);
    wr(1, modv);
    wr(2, startv);
    wr(4, polv);
    wr(3, maskv);
    for (int n = 0; n < NCH; n++) wr(8 + n, n + cofs);
    wr(0, (env << 16) | (srcv << 3) | psv);
    dv  = (srcv == 1) ? 1 : (srcv == 2) ? 2 : 3;
    len = ((modv - startv + 1) << psv) * dv;
    measure(len);
    for (int n = 0; n < NCH; n++)
      chk(tag, hi_cnt[n], exp_high(modv, startv, n + cofs, psv, dv,
                                   (polv >> n) & 1, (maskv >> n) & 1, (env >> n) & 1));
  endtask

  initial begin
    #2000000;
    n_fail++;
    $display("FAIL watchdog got=hung exp=done");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) cyc();
    rst_n = 1'b1;

    // R1: outputs low out of reset
    for (int i = 0; i < 4; i++) begin
      cyc();
      chk("R1", int'(pwm_out), 0);
    end

    // R2: duty sweep over terminal values, thresholds 0..7
    for (int m = 0; m < 7; m++) run_cfg("R2", m, 0, 1, 0, 0, 0, 'hFF, 0);
    run_cfg("R2", 2, 0, 1, 0, 0, 0, 'hFF, 3);

    // R3: prescale codes including the largest
    for (int p = 1; p < 4; p++) run_cfg("R3", 3, p, 1, 0, 0, 0, 'hFF, 0);
    run_cfg("R3", 0, 7, 1, 0, 0, 0, 'hFF, 0);

    // R4: alternative sources, then stop holds count at start
    run_cfg("R4", 4, 1, 2, 0, 0, 0, 'hFF, 0);
    run_cfg("R4", 3, 0, 3, 0, 0, 0, 'hFF, 0);
    wr(0, 'hFF << 16);
    for (int i = 0; i < 10; i++) begin
      cyc();
      chk("R4", int'(pwm_out), 'hFE);
    end

    // R5: non-zero start value
    run_cfg("R5", 5, 0, 1, 2, 0, 0, 'hFF, 0);
    run_cfg("R5", 5, 1, 1, 2, 0, 0, 'hFF, 1);

    // R6: masked channels sit at their inactive level
    run_cfg("R6", 3, 0, 1, 0, 'h0F, 'hA5, 'hFF, 0);

    // R7: inversion
    run_cfg("R7", 4, 0, 1, 0, 'hFF, 0, 'hFF, 0);
    run_cfg("R7", 4, 1, 1, 0, 'h55, 0, 'hFF, 0);

    // R10: disabled channels low even when inverted
    run_cfg("R10", 3, 0, 1, 0, 'hF0, 0, 'h0F, 0);

    // R8: lock blocks mask, inversion and control writes
    run_cfg("R8", 3, 0, 1, 0, 0, 0, 'hFF, 0);
    wr(5, 1);
    wr(3, 'hFF);
    wr(4, 'hFF);
    wr(0, 0);
    measure(4);
    for (int n = 0; n < NCH; n++)
      chk("R8", hi_cnt[n], exp_high(3, 0, n, 0, 1, 0, 0, 1));
    wr(6, 1);
    wr(3, 'hFF);
    measure(4);
    for (int n = 0; n < NCH; n++) chk("R8", hi_cnt[n], 0);

    // R9: mid-period threshold and terminal writes wait for the wrap
    wr(0, 0);
    wr(1, 7);
    wr(2, 0);
    wr(4, 0);
    wr(3, 0);
    wr(8, 2);
    wr(0, ('hFF << 16) | (1 << 3));   // count 0 now
    repeat (4) cyc();                 // count 4
    wr(8, 6);                         // count 5, old threshold 2 still used
    chk("R9", int'(pwm_out[0]), 0);
    repeat (8) cyc();                 // wrapped, count 5 with threshold 6
    chk("R9", int'(pwm_out[0]), 1);
    wr(1, 3);                         // count 6, old terminal 7 still used
    chk("R9", int'(pwm_out[0]), 0);
    cyc();                            // count 7
    measure(8);                       // two periods of 4 under terminal 3
    chk("R9", hi_cnt[0], 8);

    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

endmodule